// File: doc/BRIEF.md
# Supply and Die-Temperature Start-Up Guard

This block decides when a half-bridge power stage may switch. It watches a digitised supply reading and a digitised die-temperature reading, together with an enable input. From these it produces one registered `ready` line for the gate-drive sequencer. The sequencer must hold both switches off whenever `ready` is low.

A hysteretic undervoltage lock keeps the stage idle on a weak supply. Each time the supply climbs out of lockout, the block opens a calibration hold of fixed length. The zero-current comparator trims itself during this hold, so `ready` stays low and switching commands are of no effect. A single-cycle `cal_start` pulse tells the trim engine to begin, and `calibrating` stays high for the whole hold. If the supply sags into lockout during the hold, the hold is abandoned, and the next recovery runs a complete new hold.

An over-temperature lock with its own hysteresis forces `ready` low while the die is hot. A build parameter removes this lock entirely. Supply codes are in 10 mV steps and temperature codes are in 1 degree C steps, both unsigned.

Top module: `pwr_guard`

## Requirements
- R1: While reset is applied and until the first input-driven change after release, `ready`, `cal_start`, `calibrating` and `thermal_shutdown` are 0 and `uvlo_active` is 1.
- R2: While `uvlo_active` is 1, it clears at the clock edge after `supply_code` reaches UV_RISE (default 435) or more; any code below UV_RISE keeps it set.
- R3: Once `uvlo_active` is 0, it stays 0 while `supply_code` is at least UV_RISE-UV_HYST (default 415), and it sets at the edge after the code falls below that level.
- R4: The edge that clears `uvlo_active` also raises `calibrating` and raises `cal_start` for exactly one cycle.
- R5: When the supply stays good, `calibrating` stays high for exactly CAL_CYCLES cycles and then falls.
- R6: `ready` is 0 for every cycle in which `calibrating` is 1, whatever the state of `enable`, and `enable` does not alter the length of the hold.
- R7: `ready` is 1 at the edge after all of these hold: out of lockout, hold finished, `enable` high, no over-temperature lock. It returns to 0 at the edge after any one of them fails.
- R8: If the supply falls below UV_RISE-UV_HYST during a hold, `calibrating` drops at the next edge. The next recovery starts a full new hold of CAL_CYCLES cycles.
- R9: Every exit from lockout, including one after a finished hold, starts a new hold with a new `cal_start` pulse.
- R10: With TSD_EN=1, `thermal_shutdown` sets and `ready` falls at the edge after `temp_code` exceeds OT_TRIP (default 170). A code equal to OT_TRIP does not trip.
- R11: With TSD_EN=1, `thermal_shutdown` stays set while `temp_code` exceeds OT_TRIP-OT_HYST (default 150), and clears at the edge after it is at or below that value.
- R12: With TSD_EN=0, `thermal_shutdown` is always 0 and `temp_code` has no effect on `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Stage enable from the controller |
| supply_code | input | SUP_W | Supply reading, 10 mV per LSB |
| temp_code | input | TEMP_W | Die temperature, 1 degree C per LSB |
| ready | output | 1 | Stage may switch |
| cal_start | output | 1 | One-cycle pulse at the start of a hold |
| calibrating | output | 1 | Calibration hold in progress |
| uvlo_active | output | 1 | Supply lockout status |
| thermal_shutdown | output | 1 | Over-temperature lock status |

## Verification
The bench places the supply code exactly on each side of the rising and falling levels, and the temperature code exactly on each side of the trip and release levels. A design with an off-by-one or missing hysteresis would trip or release one code early. The bench counts the hold length to the cycle, so a counter that ends one cycle off is caught. It cuts a hold short by sagging the supply, then checks that the next recovery gives a full-length hold; a design that resumed the old count would clear early. It also holds `enable` low through a hold, raises the temperature on a build without the thermal option, and repeats a recovery after a finished hold. A guard that let `enable` or temperature leak into the hold or the result, or that calibrated only once, would show a wrong `ready` or a missing `cal_start`.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_CAL  = 2'd1,
    ST_RUN  = 2'd2
  } guard_state_e;
endpackage

// File: rtl/pwr_guard_hyst.sv
// Registered comparator with hysteresis: sets at code >= SET_AT, clears at code < CLR_AT.
module pwr_guard_hyst #(
  parameter int W      = 10,
  parameter int SET_AT = 435,
  parameter int CLR_AT = 415
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         flag_d,
  output logic         flag_q
);
  localparam logic [W-1:0] SET_V = W'(SET_AT);
  localparam logic [W-1:0] CLR_V = W'(CLR_AT);

  always_comb begin
    if (flag_q) flag_d = (code >= CLR_V);
    else        flag_d = (code >= SET_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/pwr_guard_seq.sv
// Calibration hold sequencer: lockout -> hold -> run.
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int CAL_CYCLES = 2800000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sup_ok_d,
  output guard_state_e state_d,
  output logic         cal_start_q,
  output logic         calibrating_q
);
  localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

  guard_state_e     state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             start_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    unique case (state_q)
      ST_LOCK: begin
        if (sup_ok_d) begin
          state_d = ST_CAL;
          cnt_d   = '0;
          start_d = 1'b1;
        end
      end
      ST_CAL: begin
        if (!sup_ok_d)         state_d = ST_LOCK;
        else if (cnt_q == LAST) state_d = ST_RUN;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_RUN: begin
        if (!sup_ok_d) state_d = ST_LOCK;
      end
      default: state_d = ST_LOCK;
    endcase
  end

  assign cnt_en = start_d || (state_q == ST_CAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_LOCK;
      cal_start_q   <= 1'b0;
      calibrating_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      cal_start_q   <= start_d;
      calibrating_q <= (state_d == ST_CAL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int SUP_W      = 10,
  parameter int UV_RISE    = 435,
  parameter int UV_HYST    = 20,
  parameter int TEMP_W     = 8,
  parameter int OT_TRIP    = 170,
  parameter int OT_HYST    = 20,
  parameter int CAL_CYCLES = 2800000,
  parameter bit TSD_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SUP_W-1:0]  supply_code,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              ready,
  output logic              cal_start,
  output logic              calibrating,
  output logic              uvlo_active,
  output logic              thermal_shutdown
);
  localparam int UV_FALL = UV_RISE - UV_HYST;
  localparam int OT_SET  = OT_TRIP + 1;
  localparam int OT_CLR  = OT_TRIP - OT_HYST + 1;

  logic [1:0]   rst_pipe;
  logic         rst_int_n;
  logic         sup_ok_d, sup_ok_q;
  logic         hot_d, hot_q;
  logic         ready_d, ready_q;
  guard_state_e state_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pwr_guard_hyst #(.W(SUP_W), .SET_AT(UV_RISE), .CLR_AT(UV_FALL)) u_uvlo (
    .clk(clk), .rst_n(rst_int_n), .code(supply_code),
    .flag_d(sup_ok_d), .flag_q(sup_ok_q)
  );

  generate
    if (TSD_EN) begin : g_tsd
      pwr_guard_hyst #(.W(TEMP_W), .SET_AT(OT_SET), .CLR_AT(OT_CLR)) u_ot (
        .clk(clk), .rst_n(rst_int_n), .code(temp_code),
        .flag_d(hot_d), .flag_q(hot_q)
      );
    end else begin : g_no_tsd
      logic [TEMP_W-1:0] temp_unused;
      assign temp_unused = temp_code;
      assign hot_d = 1'b0;
      assign hot_q = 1'b0;
    end
  endgenerate

  pwr_guard_seq #(.CAL_CYCLES(CAL_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .sup_ok_d(sup_ok_d),
    .state_d(state_d), .cal_start_q(cal_start), .calibrating_q(calibrating)
  );

  assign ready_d = (state_d == ST_RUN) && sup_ok_d && enable && !hot_d;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ready_q <= 1'b0;
    else            ready_q <= ready_d;
  end

  assign ready            = ready_q;
  assign uvlo_active      = !sup_ok_q;
  assign thermal_shutdown = hot_q;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int CAL_CYCLES = 2800000,
  parameter bit TSD_EN     = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic ready,
  input logic cal_start,
  input logic calibrating,
  input logic uvlo_active,
  input logic thermal_shutdown
);
  logic [31:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_cnt <= '0;
    else if (calibrating) hold_cnt <= hold_cnt + 1'b1;
    else                  hold_cnt <= '0;
  end

  assert_start_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> calibrating);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  assert_no_ready_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!calibrating && !uvlo_active && !thermal_shutdown));
  assert_lock_ends_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_active |-> !calibrating);
  assert_ready_rise_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(enable));
  assert_hold_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    calibrating |-> (hold_cnt < 32'(CAL_CYCLES)));

  generate
    if (!TSD_EN) begin : g_no_tsd
      assert_tsd_absent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !thermal_shutdown);
    end
  endgenerate
endmodule

bind pwr_guard pwr_guard_chk #(.CAL_CYCLES(CAL_CYCLES), .TSD_EN(TSD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ready(ready),
  .cal_start(cal_start), .calibrating(calibrating),
  .uvlo_active(uvlo_active), .thermal_shutdown(thermal_shutdown)
);

// File: tb/pwr_guard_test.sv
module pwr_guard_test;
  localparam int CLK_P = 10;
  localparam int NCAL  = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [9:0] supply_code;
  logic [7:0] temp_code;
  logic ready, cal_start, calibrating, uvlo_active, thermal_shutdown;
  logic nt_ready, nt_cal_start, nt_calibrating, nt_uvlo, nt_thermal;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_guard #(.CAL_CYCLES(NCAL), .TSD_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_code(supply_code),
    .temp_code(temp_code), .ready(ready), .cal_start(cal_start),
    .calibrating(calibrating), .uvlo_active(uvlo_active),
    .thermal_shutdown(thermal_shutdown)
  );

  pwr_guard #(.CAL_CYCLES(NCAL), .TSD_EN(1'b0)) uut_nt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_code(supply_code),
    .temp_code(temp_code), .ready(nt_ready), .cal_start(nt_cal_start),
    .calibrating(nt_calibrating), .uvlo_active(nt_uvlo),
    .thermal_shutdown(nt_thermal)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b1; supply_code = 10'd0; temp_code = 8'd25;
    step(3);
    check("R1 ready", ready, 1'b0);
    check("R1 uvlo", uvlo_active, 1'b1);
    rst_n = 1'b1;
    step(4);
    check("R1 ready after release", ready, 1'b0);
    check("R1 cal_start", cal_start, 1'b0);
    check("R1 calibrating", calibrating, 1'b0);
    check("R1 uvlo after release", uvlo_active, 1'b1);
    check("R1 thermal", thermal_shutdown, 1'b0);
  endtask

  // full power-up from lockout with enable as set by caller
  task automatic t_powerup(input logic en_exp);
    supply_code = 10'd434;
    step(2);
    check("R2 below rise stays locked", uvlo_active, 1'b1);
    supply_code = 10'd435;
    step(1);
    check("R2 rise clears lock", uvlo_active, 1'b0);
    check("R4 calibrating raised", calibrating, 1'b1);
    check("R4 cal_start pulse", cal_start, 1'b1);
    step(1);
    check("R4 cal_start one cycle", cal_start, 1'b0);
    step(NCAL - 2);
    check("R5 still calibrating at last cycle", calibrating, 1'b1);
    check("R6 ready low in hold", ready, 1'b0);
    step(1);
    check("R5 hold ended", calibrating, 1'b0);
    check("R7 ready after hold", ready, en_exp);
  endtask

  task automatic t_enable;
    enable = 1'b0;
    t_powerup(1'b0);
    step(2);
    check("R6 ready stays low with enable low", ready, 1'b0);
    enable = 1'b1;
    step(1);
    check("R7 ready follows enable", ready, 1'b1);
    enable = 1'b0;
    step(1);
    check("R7 ready drops with enable", ready, 1'b0);
    enable = 1'b1;
    step(1);
  endtask

  task automatic t_hyst_recal;
    supply_code = 10'd415;
    step(2);
    check("R3 at fall level stays good", uvlo_active, 1'b0);
    check("R3 ready kept", ready, 1'b1);
    supply_code = 10'd414;
    step(1);
    check("R3 below fall locks", uvlo_active, 1'b1);
    check("R7 ready drops on lock", ready, 1'b0);
    supply_code = 10'd434;
    step(2);
    check("R2 inside band stays locked", uvlo_active, 1'b1);
    supply_code = 10'd435;
    step(1);
    check("R9 recalibration starts", calibrating, 1'b1);
    check("R9 new cal_start", cal_start, 1'b1);
    step(NCAL);
    check("R9 recalibration done", ready, 1'b1);
  endtask

  task automatic t_abort;
    supply_code = 10'd0;
    step(2);
    supply_code = 10'd500;
    step(6);
    check("R8 hold in progress", calibrating, 1'b1);
    supply_code = 10'd400;
    step(1);
    check("R8 hold aborted", calibrating, 1'b0);
    check("R8 lock set", uvlo_active, 1'b1);
    supply_code = 10'd500;
    step(1);
    check("R8 new hold", cal_start, 1'b1);
    step(NCAL - 1);
    check("R8 full length restart", calibrating, 1'b1);
    check("R8 no early ready", ready, 1'b0);
    step(1);
    check("R8 restart done", calibrating, 1'b0);
    check("R8 ready after restart", ready, 1'b1);
  endtask

  task automatic t_thermal;
    temp_code = 8'd170;
    step(2);
    check("R10 at trip no shutdown", thermal_shutdown, 1'b0);
    temp_code = 8'd171;
    step(1);
    check("R10 trip", thermal_shutdown, 1'b1);
    check("R10 ready low", ready, 1'b0);
    check("R12 no-tsd flag", nt_thermal, 1'b0);
    check("R12 no-tsd ready", nt_ready, 1'b1);
    temp_code = 8'd151;
    step(2);
    check("R11 held above release", thermal_shutdown, 1'b1);
    temp_code = 8'd150;
    step(1);
    check("R11 released", thermal_shutdown, 1'b0);
    check("R7 ready back", ready, 1'b1);
    temp_code = 8'd255;
    step(2);
    check("R12 hot die ignored", nt_ready, 1'b1);
    temp_code = 8'd25;
    step(2);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_hyst_recal();
    t_abort();
    t_thermal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule